// File: doc/BRIEF.md
# Dual-Channel Capture/Compare/PWM Timer Pair

This block holds two timer channels that watch one shared free-running count. Each channel either stamps the count when its pin shows a chosen edge (input capture), or drives its pin when the count reaches a programmed value (output compare and PWM). The count and its wrap strobe come from outside. A small register bus configures both channels, and each channel raises a maskable interrupt request on every capture or compare event.

The even channel can also run in buffered mode. In that mode the compare value comes from a shadow copy that reloads only at a count wrap, which gives glitch-free PWM updates. Buffered mode takes over the odd channel: the odd channel stops, loses ownership of its pin, and its value register becomes the second buffer slot. Whenever a channel's edge/level field is zero, its pin falls back to the general-purpose output supplied from outside. The channel's output latch then holds the idle level chosen by mode bit A.

Software and bench use this address map: 0 is the channel 0 control register, 1 is the channel 0 value, 2 is the channel 1 control register, and 3 is the channel 1 value. Control bits: [1:0] edge/level field, [2] mode bit A, [3] buffered-mode bit (channel 0 only), [4] interrupt enable, [7] event flag. Bits [6:5] read as 0.

Top module: `tmr_chan_pair`

## Requirements
- R1: After reset, both control registers and both value registers read 0, both irq bits are 0, both pin_own bits are 0, and pin_out equals gpio_out.
- R2: With edge/level field 00, a channel releases its pin: pin_own is 0 and pin_out follows gpio_out. The output latch takes the idle level, low when mode bit A is 1 and high when it is 0, and drives the pin as that level once a timer function is enabled.
- R3: In capture mode (field non-zero, mode bit A 0), field 01 captures rising edges, 10 captures falling edges and 11 captures both. An edge of the other polarity leaves the flag and the value register unchanged.
- R4: The pin passes through two synchronizer flops before edge detection. The flag is still 0 after the second clock edge that follows a pin change. After the third edge the flag is 1 and the value register holds the count present at that third edge.
- R5: In compare mode (field non-zero, mode bit A 1), a cycle whose count equals the compare value sets the flag. The output latch toggles for field 01, goes low for 10 and goes high for 11. A count that does not match leaves the output unchanged.
- R6: In compare mode, a wrap strobe drives the output high for field 10 and low for field 11. A compare match in the same cycle takes priority, so a compare value of 0 with the wrap at count 0 gives 0% duty.
- R7: A write with bit 7 at 0 clears the flag only if a read of that control register saw the flag set since the last write to it. An event in the same cycle as the clearing write leaves the flag set.
- R8: Each irq bit is the channel's flag ANDed with its interrupt enable.
- R9: While channel 0's buffered bit is 1, channel 1 has pin_own 0 and irq 0, produces no events, and ignores writes to its control register.
- R10: In buffered mode, channel 0 compares against a shadow value that reloads only on a wrap strobe. It reloads from whichever value register (address 1 or 3) was written last.
- R11: Channel 1 has no buffered bit: writing 1 to bit 3 of its control register reads back as 0.
- R12: Reading a value register returns the last written compare value in compare mode and the captured count after a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for reg_addr, combinational |
| cnt_val | input | CW | Shared counter value |
| cnt_ovf | input | 1 | Counter wrap strobe, asserted in the cycle the count is 0 |
| pin_in | input | 2 | Channel pin levels |
| gpio_out | input | 2 | General-purpose output level used when a pin is released |
| pin_out | output | 2 | Driven pin level |
| pin_own | output | 2 | 1 when the timer channel owns the pin |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The bound checker watches several rules on every cycle. It checks the three-cycle lag from a pin change to a rising capture, and that every capture or compare event leaves the flag set. It checks that a flag only falls after a control write with bit 7 clear, and that the odd channel stays silent and releases its pin in buffered mode. It also checks that the shadow compare value never moves between wraps, that zero-duty PWM holds the output low, and that irq never rises without flag and enable. The output actions for each edge/level code, the idle levels, the read-then-write clearing order, which buffer slot was written last, and the captured count value can only be shown by the bench's directed and random scenarios.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  localparam int unsigned CTRL_W = 8;
  localparam int unsigned B_MSA  = 2;
  localparam int unsigned B_MSB  = 3;
  localparam int unsigned B_IE   = 4;
  localparam int unsigned B_FLAG = 7;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_COMPARE = 2'd2
  } chan_mode_e;

  // Function chosen by edge/level field, mode bit A and buffered mode.
  function automatic chan_mode_e decode_mode(input logic [1:0] els, input logic msa,
                                             input logic buf_on);
    if (els == 2'b00)   return MODE_OFF;
    if (msa || buf_on)  return MODE_COMPARE;
    return MODE_CAPTURE;
  endfunction

  // Output level after a compare match.
  function automatic logic match_level(input logic [1:0] els, input logic cur);
    case (els)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  // Output level after a counter wrap (PWM period start).
  function automatic logic wrap_level(input logic [1:0] els, input logic cur);
    case (els)
      2'b10:   return 1'b1;
      2'b11:   return 1'b0;
      default: return cur;
    endcase
  endfunction

  // Whether a detected edge is one the field asks to capture.
  function automatic logic edge_wanted(input logic [1:0] els, input logic rise,
                                       input logic fall);
    return (els[0] & rise) | (els[1] & fall);
  endfunction

endpackage

// File: rtl/tcp_edge.sv
module tcp_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/tcp_chan.sv
module tcp_chan
  import tcp_pkg::*;
#(
  parameter int unsigned CW      = 16,
  parameter bit          HAS_MSB = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_val,
  input  logic          rd_ctrl,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          pin_in,
  input  logic          dis_i,
  input  logic          buf_i,
  input  logic [CW-1:0] cmp_ext,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CW-1:0] val_o,
  output logic          out_o,
  output logic          own_o,
  output logic          irq_o,
  output logic          flag_o,
  output logic          cap_evt_o,
  output logic          cmp_evt_o
);
  logic [1:0]  els;
  logic        msa, msb, ie, flag, armed, out_q;
  logic [CW-1:0] val;
  logic        rise, fall, clr_ok;
  logic [CW-1:0] cmp_use;
  chan_mode_e  mode;

  tcp_edge #(.STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .rise(rise), .fall(fall)
  );

  assign mode      = dis_i ? MODE_OFF : decode_mode(els, msa, buf_i);
  assign cmp_use   = buf_i ? cmp_ext : val;
  assign cap_evt_o = (mode == MODE_CAPTURE) && edge_wanted(els, rise, fall);
  assign cmp_evt_o = (mode == MODE_COMPARE) && (cnt_val == cmp_use);
  assign clr_ok    = wr_ctrl && !dis_i && armed && !wdata[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      els   <= 2'b00;
      msa   <= 1'b0;
      msb   <= 1'b0;
      ie    <= 1'b0;
      flag  <= 1'b0;
      armed <= 1'b0;
      val   <= '0;
      out_q <= 1'b1;
    end else begin
      if (wr_ctrl && !dis_i) begin
        els <= wdata[1:0];
        msa <= wdata[B_MSA];
        msb <= HAS_MSB ? wdata[B_MSB] : 1'b0;
        ie  <= wdata[B_IE];
      end
      if (cap_evt_o || cmp_evt_o) flag <= 1'b1;
      else if (clr_ok)            flag <= 1'b0;
      if (rd_ctrl && flag) armed <= 1'b1;
      else if (wr_ctrl)    armed <= 1'b0;
      if (cap_evt_o)   val <= cnt_val;
      else if (wr_val) val <= wdata;
      if (mode == MODE_OFF)                      out_q <= ~msa;
      else if (cmp_evt_o)                        out_q <= match_level(els, out_q);
      else if (mode == MODE_COMPARE && cnt_ovf)  out_q <= wrap_level(els, out_q);
    end
  end

  assign ctrl_o = {flag, 2'b00, ie, msb, msa, els};
  assign val_o  = val;
  assign out_o  = out_q;
  assign own_o  = (mode != MODE_OFF);
  assign irq_o  = flag & ie & ~dis_i;
  assign flag_o = flag;
endmodule

// File: rtl/tmr_chan_pair.sv
module tmr_chan_pair
  import tcp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic [1:0]    pin_in,
  input  logic [1:0]    gpio_out,
  output logic [1:0]    pin_out,
  output logic [1:0]    pin_own,
  output logic [1:0]    irq
);
  localparam int unsigned NCH = 2;

  logic [CTRL_W-1:0] ctrl_a [NCH];
  logic [CW-1:0]     val_a  [NCH];
  logic [NCH-1:0]    out_v, own_v, flag_v, cap_e, cmp_e;
  logic [NCH-1:0][1:0] els_v;
  logic              buf_on, last_odd;
  logic [CW-1:0]     act_cmp;

  assign buf_on = ctrl_a[0][B_MSB];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [1:0] A_CTRL = 2'(2 * i);
    localparam logic [1:0] A_VAL  = 2'(2 * i + 1);
    tcp_chan #(.CW(CW), .HAS_MSB(i == 0)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(reg_wr && reg_addr == A_CTRL),
      .wr_val (reg_wr && reg_addr == A_VAL),
      .rd_ctrl(reg_rd && reg_addr == A_CTRL),
      .wdata(reg_wdata), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
      .pin_in(pin_in[i]),
      .dis_i((i == 1) ? buf_on : 1'b0),
      .buf_i((i == 0) ? buf_on : 1'b0),
      .cmp_ext(act_cmp),
      .ctrl_o(ctrl_a[i]), .val_o(val_a[i]), .out_o(out_v[i]), .own_o(own_v[i]),
      .irq_o(irq[i]), .flag_o(flag_v[i]), .cap_evt_o(cap_e[i]), .cmp_evt_o(cmp_e[i])
    );
    assign els_v[i]   = ctrl_a[i][1:0];
    assign pin_own[i] = own_v[i];
    assign pin_out[i] = own_v[i] ? out_v[i] : gpio_out[i];
  end

  // Shadow compare value for buffered mode: reloads at wrap from last-written slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_odd <= 1'b0;
      act_cmp  <= '0;
    end else begin
      if (buf_on && reg_wr && reg_addr == 2'd1)      last_odd <= 1'b0;
      else if (buf_on && reg_wr && reg_addr == 2'd3) last_odd <= 1'b1;
      if (buf_on && cnt_ovf) act_cmp <= last_odd ? val_a[1] : val_a[0];
    end
  end

  always_comb begin
    if (reg_addr[0]) reg_rdata = val_a[reg_addr[1]];
    else             reg_rdata = CW'(ctrl_a[reg_addr[1]]);
  end
endmodule

// File: rtl/tcp_checker.sv
module tcp_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          wr_flag_bit,
  input logic [CW-1:0] cnt_val,
  input logic          cnt_ovf,
  input logic [1:0]    pin_in,
  input logic [1:0]    pin_own,
  input logic [1:0]    irq,
  input logic [1:0]    flag_v,
  input logic [1:0]    cap_e,
  input logic [1:0]    cmp_e,
  input logic [1:0][1:0] els_v,
  input logic          msa0,
  input logic          ie0,
  input logic          out0,
  input logic [CW-1:0] val0,
  input logic          buf_on,
  input logic [CW-1:0] act_cmp
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  for (genvar i = 0; i < 2; i++) begin : g_chk
    // R4: rising capture reflects the pin two and three samples back
    a_r4_capture_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_e[i] && els_v[i] == 2'b01 && age == 2'd3)
        |-> ($past(pin_in[i], 2) && !$past(pin_in[i], 3)));
    // R5: any event leaves the flag set
    a_r5_event_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_e[i] || cmp_e[i]) |=> flag_v[i]);
    // R7: a flag only drops after a control write with bit 7 clear
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_v[i]) |-> $past(reg_wr && reg_addr == 2'(2 * i) && !wr_flag_bit));
  end

  // R6: zero compare value with wrap at count 0 keeps the output low
  a_r6_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_own[0] && !buf_on && els_v[0] == 2'b10 && msa0 && val0 == '0 &&
     cnt_ovf && cnt_val == '0) |=> !out0);
  // R8: request never without flag and enable
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> (flag_v[0] && ie0));
  // R9: buffered mode silences and releases the odd channel
  a_r9_odd_released: assert property (@(posedge clk) disable iff (!rst_n)
    buf_on |-> (!pin_own[1] && !irq[1]));
  // R10: shadow value moves only on a wrap
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_on && !cnt_ovf) |=> $stable(act_cmp));
endmodule

bind tmr_chan_pair tcp_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wr_flag_bit(reg_wdata[7]), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
  .pin_in(pin_in), .pin_own(pin_own), .irq(irq), .flag_v(flag_v),
  .cap_e(cap_e), .cmp_e(cmp_e), .els_v(els_v), .msa0(ctrl_a[0][2]),
  .ie0(ctrl_a[0][4]), .out0(out_v[0]), .val0(val_a[0]), .buf_on(buf_on),
  .act_cmp(act_cmp)
);

// File: tb/tb_tmr_chan_pair.sv
`timescale 1ns/1ps
module tb_tmr_chan_pair;
  localparam logic [15:0] PARK = 16'd60000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, cnt_ovf = 0;
  logic [1:0] reg_addr = 0, pin_in = 0, gpio_out = 2'b10;
  logic [15:0] reg_wdata = 0, cnt_val = 0;
  logic [15:0] reg_rdata;
  logic [1:0] pin_out, pin_own, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_chan_pair #(.CW(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .pin_in(pin_in), .gpio_out(gpio_out), .pin_out(pin_out), .pin_own(pin_own), .irq(irq)
  );

  function automatic logic f_match(input logic [1:0] e, input logic cur);
    if (e == 2'b01) return !cur;
    return e == 2'b11;
  endfunction
  function automatic logic f_hit(input logic [1:0] e, input logic o, input logic n);
    return (e[0] && !o && n) || (e[1] && o && !n);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic cyc(input logic [15:0] c, input logic o);
    cnt_val = c; cnt_ovf = o;
    @(negedge clk); cnt_val = PARK; cnt_ovf = 0;
  endtask
  task automatic clear_flag(input logic [1:0] a);
    logic [15:0] t;
    rd(a, t); wr(a, t & 16'h007F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, prev, cv, v;
    logic [1:0] e;
    logic cur, np, op, hit;
    void'($urandom(32'd2024));
    cnt_val = PARK;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 2'b00);
    check("R1 own", pin_own, 2'b00);
    check("R1 pin_out", pin_out, gpio_out);
    peek(0, d); check("R1 ctrl0", d, 0);
    peek(2, d); check("R1 ctrl1", d, 0);
    peek(1, d); check("R1 val0", d, 0);
    peek(3, d); check("R1 val1", d, 0);

    // R2 idle levels
    wr(0, 16'h0004);
    check("R2 released", pin_own[0], 0);
    check("R2 gpio path", pin_out[0], gpio_out[0]);
    wr(1, 16'd5000);
    wr(0, 16'h0005);
    check("R2 owned", pin_own[0], 1);
    check("R2 idle low", pin_out[0], 0);
    wr(0, 16'h0000);
    wr(0, 16'h0005);
    check("R2 idle high", pin_out[0], 1);

    // R5 toggle, R8 masked
    cyc(16'd5000, 0);
    check("R5 toggle", pin_out[0], 0);
    peek(0, d); check("R5 flag", d[7], 1);
    check("R8 masked", irq[0], 0);

    // R7 clearing protocol
    wr(0, 16'h0005);
    peek(0, d); check("R7 no read no clear", d[7], 1);
    rd(0, d);
    wr(0, 16'h0015);
    peek(0, d); check("R7 cleared", d[7], 0);
    check("R8 no flag", irq[0], 0);
    cyc(16'd5000, 0);
    check("R8 irq", irq[0], 1);
    check("R5 toggle back", pin_out[0], 1);
    rd(0, d);
    reg_addr = 0; reg_wdata = 16'h0015; reg_wr = 1; cnt_val = 16'd5000;
    @(negedge clk); reg_wr = 0; cnt_val = PARK;
    peek(0, d); check("R7 event wins", d[7], 1);
    clear_flag(0);
    peek(0, d); check("R7 clear after read", d[7], 0);

    // R5 clear / set actions
    wr(0, 16'h0017); cyc(16'd5000, 0);
    check("R5 set", pin_out[0], 1);
    wr(0, 16'h0016); cyc(16'd5000, 0);
    check("R5 clear", pin_out[0], 0);

    // R5 / R12 random compare
    for (int k = 0; k < 8; k++) begin
      e  = 2'(1 + $urandom % 3);
      cv = 16'(1 + $urandom % 4000);
      wr(1, cv);
      wr(0, {14'd0, e} | 16'h0004);
      peek(1, d); check("R12 compare readback", d, cv);
      cur = pin_out[0];
      cyc(cv + 16'd1, 0);
      check("R5 no match", pin_out[0], cur);
      cyc(cv, 0);
      check("R5 random action", pin_out[0], f_match(e, cur));
    end

    // R6 PWM
    wr(1, 16'd3); wr(0, 16'h0006);
    cyc(16'd0, 1); check("R6 wrap high", pin_out[0], 1);
    cyc(16'd1, 0); cyc(16'd2, 0); check("R6 hold", pin_out[0], 1);
    cyc(16'd3, 0); check("R6 match low", pin_out[0], 0);
    wr(0, 16'h0007);
    cyc(16'd0, 1); check("R6 wrap low", pin_out[0], 0);
    cyc(16'd3, 0); check("R6 match high", pin_out[0], 1);
    wr(1, 16'd0); wr(0, 16'h0006);
    cyc(16'd0, 1); check("R6 zero duty", pin_out[0], 0);
    cyc(16'd1, 0); check("R6 zero duty hold", pin_out[0], 0);

    // R4 capture lag
    wr(0, 16'h0001); clear_flag(0);
    repeat (3) @(negedge clk);
    pin_in[0] = 1; cnt_val = 16'd200; @(negedge clk);
    peek(0, d); check("R4 after 1", d[7], 0);
    cnt_val = 16'd201; @(negedge clk);
    peek(0, d); check("R4 after 2", d[7], 0);
    cnt_val = 16'd202; @(negedge clk);
    cnt_val = PARK;
    peek(0, d); check("R4 after 3", d[7], 1);
    peek(1, d); check("R4 value", d, 202);
    clear_flag(0);
    pin_in[0] = 0; repeat (4) @(negedge clk);
    peek(0, d); check("R3 fall ignored", d[7], 0);
    peek(1, d); check("R3 value kept", d, 202);

    // R3 / R12 random capture
    for (int k = 0; k < 10; k++) begin
      e = 2'(1 + $urandom % 3);
      wr(0, {14'd0, e});
      clear_flag(0);
      peek(1, prev);
      op = pin_in[0]; np = 1'($urandom % 2);
      v = 16'($urandom % 50000);
      pin_in[0] = np; cnt_val = v;
      repeat (4) @(negedge clk);
      cnt_val = PARK;
      hit = f_hit(e, op, np);
      peek(0, d); check("R3 flag", d[7], hit);
      peek(1, d); check("R12 capture value", d, hit ? v : prev);
    end

    // R11 odd channel has no buffered bit
    wr(2, 16'h0008);
    peek(2, d); check("R11 no msb", d, 0);

    // R9 buffered mode releases the odd channel
    wr(3, 16'd700); wr(2, 16'h0015);
    check("R9 odd owned before", pin_own[1], 1);
    wr(1, 16'd10); wr(0, 16'h000F);
    check("R9 odd released", pin_own[1], 0);
    check("R9 odd gpio", pin_out[1], gpio_out[1]);
    cyc(16'd700, 0);
    peek(2, d); check("R9 odd no event", d[7], 0);
    check("R9 odd irq", irq[1], 0);
    wr(2, 16'h0000);
    peek(2, d); check("R9 odd write ignored", d, 16'h0015);

    // R10 shadow compare
    cyc(16'd0, 1);
    cyc(16'd0, 1); check("R10 wrap low", pin_out[0], 0);
    cyc(16'd10, 0); check("R10 loaded", pin_out[0], 1);
    wr(3, 16'd20); clear_flag(0);
    cyc(16'd20, 0);
    peek(0, d); check("R10 not yet active", d[7], 0);
    cyc(16'd0, 1); check("R10 wrap", pin_out[0], 0);
    cyc(16'd10, 0);
    peek(0, d); check("R10 old retired", d[7], 0);
    cyc(16'd20, 0); check("R10 odd slot active", pin_out[0], 1);
    wr(3, 16'd40); wr(1, 16'd30);
    cyc(16'd0, 1); clear_flag(0);
    cyc(16'd40, 0);
    peek(0, d); check("R10 older write unused", d[7], 0);
    cyc(16'd30, 0); check("R10 latest write used", pin_out[0], 1);
    check("R10 even owned", pin_own[0], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule